// File: doc/BRIEF.md
# Interrupt Acceptance and Status-Word Unit

This block keeps the three processor status fields that decide whether an interrupt may be taken: a two-bit mask level, a maskable-interrupt enable and a bank-disable flag. Every clock it looks at a non-maskable request and a maskable request tagged with a two-bit priority level. It decides whether either is accepted and, if so, updates the status word and reports the accepted source and level on a registered acknowledge.

On entry the current status word is pushed onto a small save stack. The bank-disable flag is forced on, and for a maskable entry the mask is lowered to the accepted level so that only more urgent levels can nest. A return request pops the stack and restores all three fields. Software may write the status word directly. The enable field is then taken from a separate preset register rather than from the written bit. While bank-disable is set, data addresses going out of the block are clamped into the unbanked 64 KiB window.

Top module: `irq_status_unit`

## Requirements
- R1: A non-maskable request (`nmiReq`=1) is accepted in every cycle, whatever the enable and mask fields hold. When it arrives together with a maskable request, the non-maskable one is taken and the maskable one is dropped for that cycle.
- R2: While the enable field is 0, no maskable request is accepted.
- R3: With enable at 1, a maskable request of level L is accepted exactly when L is numerically less than the mask. Mask 0 accepts none, mask 1 accepts level 0, mask 2 accepts levels 0-1, and mask 3 accepts levels 0-2.
- R4: A maskable request of level 3 is never accepted.
- R5: On any accepted entry, bank-disable becomes 1 and enable is left unchanged. A maskable entry at level L sets the mask to L. A non-maskable entry leaves the mask unchanged.
- R6: An accepted request raises `ackValid` for one cycle, in the cycle after the request. `ackNmi` and `ackLevel` report the source and level in that cycle (level 0 for a non-maskable entry). All three are 0 in a cycle without an acknowledge.
- R7: An entry pushes the status word as it stood before entry. A return (`retiReq`) pops the most recent saved word and restores mask, enable and bank-disable from it, so bank-disable regains its pre-entry value even if a handler changed it.
- R8: An entry with `STACK_DEPTH` words already saved is still accepted, but its word is not saved. A return with nothing saved changes no state. Either case pulses `stackErr` for one cycle in the following cycle.
- R9: A software write (`swWr`) loads `swData` as bit 3 bank-disable, bit 2 enable, bits 1:0 mask. Writing enable as 1 loads the preset register's value into it, and writing it as 0 clears it. `presetWr` loads `presetVal` into the preset register. A status write in the same cycle uses the preset value from before that cycle.
- R10: While bank-disable is 1, `addrOut` holds `addrIn` with every bit above bit 15 forced to 0. While it is 0, `addrOut` equals `addrIn`.
- R11: In one cycle, acceptance takes precedence over a return, and a return takes precedence over a software status write. The lower-ranked requests have no effect in that cycle.
- R12: After reset, mask is 0, enable is 0, bank-disable is 0, the preset register is 1, the save stack is empty, and `ackValid`, `ackNmi`, `ackLevel` and `stackErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable interrupt request |
| mskReq | input | 1 | Maskable interrupt request |
| mskLevel | input | 2 | Priority level of the maskable request (0 most urgent) |
| retiReq | input | 1 | Return from interrupt: pop the saved status word |
| swWr | input | 1 | Software write of the status word |
| swData | input | 4 | Status word to write: bankDis, enable, mask[1:0] |
| presetWr | input | 1 | Write strobe for the enable preset register |
| presetVal | input | 1 | Value for the enable preset register |
| addrIn | input | ADDR_W | Data address from the core |
| addrOut | output | ADDR_W | Data address after window gating |
| statusMask | output | 2 | Current mask level |
| statusEn | output | 1 | Current maskable-interrupt enable |
| statusBankDis | output | 1 | Current bank-disable flag |
| ackValid | output | 1 | One-cycle acknowledge of an accepted request |
| ackNmi | output | 1 | Acknowledged request was non-maskable |
| ackLevel | output | 2 | Level of the acknowledged maskable request |
| stackErr | output | 1 | One-cycle pulse on save-stack overflow or underflow |

## Verification
The embedded assertions watch, on every cycle, that a maskable acknowledge never reports level 3 and is never granted while enable was clear. They also check that it leaves the mask equal to its level, that a non-maskable request is always acknowledged next cycle, that entry forces bank-disable, that a push onto a full stack flags an error, and that gated addresses keep their upper bits clear. Only the bench's scenarios can show that a return restores the exact pre-entry word after nested entries and handler edits. The same holds for the same-cycle precedence among entry, return and software write, and for the enable preset taking effect on a write. The bench tracks these with a behavioural model over both directed sequences and random traffic.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 2;

  // bit 3 bankDis, bit 2 intEn, bits 1:0 mask
  typedef struct packed {
    logic             bankDis;
    logic             intEn;
    logic [LVL_W-1:0] mask;
  } statusT;

  typedef struct packed {
    logic             enter;
    logic             viaNmi;
    logic [LVL_W-1:0] lvl;
    logic             pop;
    logic             swWrite;
  } strobeT;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiReq,
  input  logic             mskReq,
  input  logic [LVL_W-1:0] mskLevel,
  input  logic             retiReq,
  input  logic             swWr,
  input  statusT           st,
  output strobeT           strb,
  output logic             ackValid,
  output logic             ackNmi,
  output logic [LVL_W-1:0] ackLevel
);
  logic mskOk;
  logic accept;

  always_comb begin
    mskOk        = mskReq && st.intEn && (mskLevel < st.mask);
    accept       = nmiReq || mskOk;
    strb.enter   = accept;
    strb.viaNmi  = nmiReq;
    strb.lvl     = mskLevel;
    strb.pop     = !accept && retiReq;
    strb.swWrite = !accept && !retiReq && swWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackNmi   <= 1'b0;
      ackLevel <= '0;
    end else begin
      ackValid <= accept;
      ackNmi   <= nmiReq;
      ackLevel <= (accept && !nmiReq) ? mskLevel : '0;
    end
  end

  // R4
  level3_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && !ackNmi |-> ackLevel != 2'd3);
  // R2
  disabled_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && !ackNmi |-> $past(st.intEn));
  // R5
  nest_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && !ackNmi |-> st.mask == ackLevel);
  // R1
  nmi_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> ackValid && ackNmi);
endmodule

// File: rtl/irq_dpath.sv
module irq_dpath
  import irq_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int ADDR_W      = 20,
  parameter int WIN_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [3:0]        swData,
  input  logic              presetWr,
  input  logic              presetVal,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output statusT            st,
  output logic              stackErr
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  statusT           stk [STACK_DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             preset;
  logic             isFull;
  logic             isEmpty;
  logic [IDX_W-1:0] topIdx;

  assign isFull  = (cnt == CNT_W'(STACK_DEPTH));
  assign isEmpty = (cnt == '0);
  assign topIdx  = IDX_W'(cnt - CNT_W'(1));

  for (genvar i = 0; i < STACK_DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        stk[i] <= '0;
      else if (strb.enter && cnt == CNT_W'(i))
        stk[i] <= st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= '0;
      cnt      <= '0;
      preset   <= 1'b1;
      stackErr <= 1'b0;
    end else begin
      stackErr <= 1'b0;
      if (presetWr) preset <= presetVal;
      if (strb.enter) begin
        st.bankDis <= 1'b1;
        if (!strb.viaNmi) st.mask <= strb.lvl;
        if (isFull) stackErr <= 1'b1;
        else        cnt      <= cnt + CNT_W'(1);
      end else if (strb.pop) begin
        if (isEmpty) begin
          stackErr <= 1'b1;
        end else begin
          st  <= stk[topIdx];
          cnt <= cnt - CNT_W'(1);
        end
      end else if (strb.swWrite) begin
        st.bankDis <= swData[3];
        st.intEn   <= swData[2] ? preset : 1'b0;
        st.mask    <= swData[1:0];
      end
    end
  end

  if (ADDR_W > WIN_W) begin : gGate
    assign addrOut = st.bankDis ? {{(ADDR_W-WIN_W){1'b0}}, addrIn[WIN_W-1:0]} : addrIn;
    // R10
    window_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      st.bankDis |-> addrOut[ADDR_W-1:WIN_W] == '0);
  end else begin : gPass
    assign addrOut = addrIn;
  end

  // R5
  entry_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.enter |=> st.bankDis);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.enter && isFull |=> stackErr);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop && isEmpty |=> stackErr && $stable(cnt));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int ADDR_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              mskReq,
  input  logic [1:0]        mskLevel,
  input  logic              retiReq,
  input  logic              swWr,
  input  logic [3:0]        swData,
  input  logic              presetWr,
  input  logic              presetVal,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        statusMask,
  output logic              statusEn,
  output logic              statusBankDis,
  output logic              ackValid,
  output logic              ackNmi,
  output logic [1:0]        ackLevel,
  output logic              stackErr
);
  statusT st;
  strobeT strb;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .mskReq(mskReq),
    .mskLevel(mskLevel), .retiReq(retiReq), .swWr(swWr), .st(st),
    .strb(strb), .ackValid(ackValid), .ackNmi(ackNmi), .ackLevel(ackLevel)
  );

  irq_dpath #(.STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W), .WIN_W(16)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .swData(swData),
    .presetWr(presetWr), .presetVal(presetVal), .addrIn(addrIn),
    .addrOut(addrOut), .st(st), .stackErr(stackErr)
  );

  assign statusMask    = st.mask;
  assign statusEn      = st.intEn;
  assign statusBankDis = st.bankDis;
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          nmiReq, mskReq, retiReq, swWr, presetWr, presetVal;
  logic [1:0]    mskLevel;
  logic [3:0]    swData;
  logic [AW-1:0] addrIn;
  logic [AW-1:0] addrOut;
  logic [1:0]    statusMask, ackLevel;
  logic          statusEn, statusBankDis, ackValid, ackNmi, stackErr;

  int total = 0;
  int bad   = 0;
  string curTag = "R12";

  // behavioural model
  int mMask, mEn, mBank, mPreset, mAckV, mAckNmi, mAckLvl, mErr;
  int mStk[$];

  always #4 clk = ~clk;

  irq_status_unit #(.STACK_DEPTH(DEPTH), .ADDR_W(AW)) u_irq_status_unit (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .mskReq(mskReq), .mskLevel(mskLevel),
    .retiReq(retiReq), .swWr(swWr), .swData(swData), .presetWr(presetWr),
    .presetVal(presetVal), .addrIn(addrIn), .addrOut(addrOut),
    .statusMask(statusMask), .statusEn(statusEn), .statusBankDis(statusBankDis),
    .ackValid(ackValid), .ackNmi(ackNmi), .ackLevel(ackLevel), .stackErr(stackErr)
  );

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expAddr;
    expAddr = mBank ? (int'(addrIn) & 32'hFFFF) : int'(addrIn);
    chk("ackValid", int'(ackValid), mAckV);
    chk("ackNmi", int'(ackNmi), mAckNmi);
    chk("ackLevel", int'(ackLevel), mAckLvl);
    chk("stackErr", int'(stackErr), mErr);
    chk("status", int'({statusBankDis, statusEn, statusMask}), mBank*8 + mEn*4 + mMask);
    chk("addrOut", int'(addrOut), expAddr);
  endtask

  task automatic modelReset();
    mMask = 0; mEn = 0; mBank = 0; mPreset = 1;
    mAckV = 0; mAckNmi = 0; mAckLvl = 0; mErr = 0;
    mStk.delete();
  endtask

  task automatic modelStep();
    bit take;
    take = nmiReq || (mskReq && mEn == 1 && int'(mskLevel) < mMask);
    mAckV   = take;
    mAckNmi = nmiReq;
    mAckLvl = (take && !nmiReq) ? int'(mskLevel) : 0;
    mErr    = 0;
    if (take) begin
      if (mStk.size() < DEPTH) mStk.push_back(mBank*8 + mEn*4 + mMask);
      else mErr = 1;
      mBank = 1;
      if (!nmiReq) mMask = int'(mskLevel);
    end else if (retiReq) begin
      if (mStk.size() == 0) mErr = 1;
      else begin
        int w;
        w = mStk.pop_back();
        mBank = (w >> 3) & 1; mEn = (w >> 2) & 1; mMask = w & 3;
      end
    end else if (swWr) begin
      mBank = int'(swData[3]);
      mEn   = swData[2] ? mPreset : 0;
      mMask = int'(swData[1:0]);
    end
    if (presetWr) mPreset = int'(presetVal);
  endtask

  // one cycle: inputs are driven now (at a falling edge), results checked next falling edge
  task automatic step(bit n, bit m, int lvl, bit r, bit w, int d, bit pw, bit pv, int a);
    nmiReq = n; mskReq = m; mskLevel = 2'(lvl); retiReq = r; swWr = w;
    swData = 4'(d); presetWr = pw; presetVal = pv; addrIn = AW'(a);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int a);
    step(0, 0, 0, 0, 0, 0, 0, 0, a);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rstN = 1'b0;
    nmiReq = 0; mskReq = 0; mskLevel = 0; retiReq = 0; swWr = 0;
    swData = 0; presetWr = 0; presetVal = 0; addrIn = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: reset state
    curTag = "R12";
    addrIn = AW'(32'hABCDE);
    #1 compareAll();
    idle(32'h5A5A5);

    // R2: enable clear blocks every level
    curTag = "R2";
    for (int l = 0; l < 4; l++) step(0, 1, l, 0, 0, 0, 0, 0, 32'h12345);

    // R9: status write with enable taken from preset (preset=1)
    curTag = "R9";
    step(0, 0, 0, 0, 1, 4'b0111, 0, 0, 32'hF0000);
    // R4: level 3 never taken even at mask 3
    curTag = "R4";
    step(0, 1, 3, 0, 0, 0, 0, 0, 32'hF1234);
    // R3/R5/R6: level 2 accepted at mask 3, mask becomes 2, bankDis set
    curTag = "R3";
    step(0, 1, 2, 0, 0, 0, 0, 0, 32'hF1234);
    curTag = "R6";
    idle(32'hF1234);
    // R3: level 2 refused at mask 2, level 1 nests
    curTag = "R3";
    step(0, 1, 2, 0, 0, 0, 0, 0, 32'h31234);
    curTag = "R5";
    step(0, 1, 1, 0, 0, 0, 0, 0, 32'h31234);
    // R1: NMI and maskable together, NMI wins, mask stays 1
    curTag = "R1";
    step(1, 1, 0, 0, 0, 0, 0, 0, 32'h31234);
    // R1: NMI with enable clear via handler write
    step(0, 0, 0, 0, 1, 4'b0000, 0, 0, 32'h71234);
    step(1, 0, 0, 0, 0, 0, 0, 0, 32'h71234);
    // R10: bankDis 1 gates address
    curTag = "R10";
    idle(32'hFFFFF);
    // R7: handler clears bankDis, returns restore saved words
    curTag = "R7";
    step(0, 0, 0, 0, 1, 4'b0000, 0, 0, 32'h8ABCD);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0, 0, 0, 32'h8ABCD);
    // R8: return with empty stack
    curTag = "R8";
    step(0, 0, 0, 1, 0, 0, 0, 0, 32'h8ABCD);
    idle(32'h8ABCD);
    // R8: overflow, five NMIs with depth four
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 32'h4ABCD);
    idle(32'h4ABCD);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1, 0, 0, 0, 0, 32'h4ABCD);
    // R9: preset cleared, writing enable 1 yields 0; same-cycle preset write uses old value
    curTag = "R9";
    step(0, 0, 0, 0, 1, 4'b0111, 1, 0, 32'h2ABCD);
    step(0, 0, 0, 0, 1, 4'b0111, 1, 1, 32'h2ABCD);
    step(0, 0, 0, 0, 1, 4'b0111, 0, 0, 32'h2ABCD);
    // R11: entry beats return and write; return beats write
    curTag = "R11";
    step(0, 1, 0, 1, 1, 4'b0000, 0, 0, 32'h2ABCD);
    step(0, 0, 0, 1, 1, 4'b1001, 0, 0, 32'h2ABCD);
    step(0, 1, 0, 0, 0, 0, 0, 0, 32'h2ABCD);
    step(0, 0, 0, 1, 1, 4'b1001, 0, 0, 32'h2ABCD);

    // random traffic against the model
    curTag = "R6";
    for (int k = 0; k < 600; k++) begin
      bit n, m, r, w, pw;
      n  = ($urandom % 10) == 0;
      m  = ($urandom % 2) == 0;
      r  = ($urandom % 4) == 0;
      w  = ($urandom % 6) == 0;
      pw = ($urandom % 12) == 0;
      step(n, m, int'($urandom % 4), r, w, int'($urandom % 16), pw,
           1'($urandom % 2), int'($urandom % 32'h100000));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule